// File: doc/BRIEF.md
# Host bridge reset controller

This block produces every reset and start-up line of a host-to-PCI bridge from one host clock. A power-good input, a static role strap and three one-cycle command strobes drive it. The strobes come from the bridge's register decode: a hard-reset command, a PCI-only reset command and a processor soft-init command. A configuration bit asks the processor to run its built-in self test. From these inputs the block drives an active-low host bus reset with its output enable, an active-low PCI bus reset, an active-low processor soft-init line, a PCI clock at half the host clock rate, and an internal reset for the bridge's ordinary registers.

A bridge strapped as primary owns the host reset. It holds the host reset after power-up and on a hard-reset command. An auxiliary bridge never drives the host reset. It samples that line as an input instead, and it keeps soft-init idle. In both roles the PCI reset follows power-good directly, so PCI outputs float while power is not good. A PCI-only reset leaves the host side alone. Registers that must survive a reset, such as the device number and the configuration captured at reset, are simply not wired to the internal register reset.

Top module: `hbr_rst_ctrl`

## Requirements
- R1: In both roles, `pci_rst_n_o` is low in the same cycle in which `pwr_good_i` is low, with no clock delay.
- R2: In the primary role (`primary_i`=1), the host reset is low while power-good is low. Power-good passes through two synchronizing flops. The host reset is then held for 64 more cycles, so it is released on the 66th rising edge after power-good rises. The PCI reset is released at the same edge.
- R3: In the primary role, a `hard_wr_i` strobe sampled at edge N holds `host_rst_n_o` and `pci_rst_n_o` low from edge N to edge N+16. Both lines are released at edge N+16. A new strobe during the pulse restarts the 16-cycle count.
- R4: In either role, a `pci_wr_i` strobe sampled at edge N holds `pci_rst_n_o` low from edge N until edge N+16. `host_rst_n_o` is not affected.
- R5: In the auxiliary role (`primary_i`=0), `host_rst_oe_o` is 0 and `host_rst_n_o` is 1. `soft_init_n_o` stays 1, and `hard_wr_i` and `init_wr_i` have no effect. `host_rst_n_i` passes through two flops and then sets `reg_rst_o` and holds `pci_rst_n_o` low. Power-good does not act as a power-on reset in this role.
- R6: In the primary role, with the host reset released, an `init_wr_i` strobe sampled at edge N drives `soft_init_n_o` low from edge N to edge N+16. A strobe that arrives during a pulse is ignored, and so is a strobe that arrives while the host reset is active.
- R7: In the primary role with `bist_en_i`=1, `soft_init_n_o` is low for the whole host reset and for 16 cycles after the reset is released. With `bist_en_i`=0, `soft_init_n_o` stays 1 during a host reset.
- R8: `pci_clk_o` is 0 in reset and toggles on every host clock edge afterwards, which gives half the host frequency.
- R9: `reg_rst_o` is 1 exactly while the host reset is active. In the primary role that is the driven host reset. In the auxiliary role it is the sampled input.
- R10: While `rst` is high, the primary host reset is low, `soft_init_n_o` is 1 and `pci_clk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Power-good, asynchronous |
| primary_i | input | 1 | Role strap: 1 primary, 0 auxiliary |
| hard_wr_i | input | 1 | Hard-reset command strobe |
| pci_wr_i | input | 1 | PCI-only reset command strobe |
| init_wr_i | input | 1 | Soft-init command strobe |
| bist_en_i | input | 1 | Keep soft-init asserted across the host reset release |
| host_rst_n_i | input | 1 | Host reset line sampled in the auxiliary role |
| host_rst_n_o | output | 1 | Host reset drive value, active low |
| host_rst_oe_o | output | 1 | Host reset output enable |
| pci_rst_n_o | output | 1 | PCI bus reset, active low |
| soft_init_n_o | output | 1 | Processor soft-init, active low |
| pci_clk_o | output | 1 | Half-rate PCI clock |
| reg_rst_o | output | 1 | Reset for the ordinary bridge registers |

## Verification
Every piece of state here is a down counter or a synchronizer flop. A wrong value shows up as a reset or init edge at the wrong cycle, so the checks look at each edge on the cycle where it should happen and on the cycle before. A counter that loads the wrong length moves the release edge by a fixed number of cycles, and this is visible within 17 cycles of a strobe, or 67 cycles for power-up. A missing synchronizer stage shifts the auxiliary input's effect by one cycle. A gating error between the roles shows up as a line that moves when it should stay still, on the cycle right after the strobe.

// File: rtl/hbr_rst_pkg.sv
package hbr_rst_pkg;

    localparam int unsigned POR_HOLD_CYC = 64;
    localparam int unsigned PULSE_CYC    = 16;

    typedef enum logic {
        ROLE_AUX     = 1'b0,
        ROLE_PRIMARY = 1'b1
    } role_e;

    // Active-high reset causes, gathered before the output gating
    typedef struct packed {
        logic por;     // power-on hold (primary only)
        logic hard;    // programmed hard reset (primary only)
        logic pci;     // programmed PCI-only reset
        logic aux_in;  // sampled external host reset (auxiliary only)
    } rst_cause_t;

    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hbr_sync2.sv
module hbr_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= d_i[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/hbr_pulse_cnt.sv
module hbr_pulse_cnt #(
    parameter int unsigned LEN    = 16,
    parameter bit          RETRIG = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,    // force idle
    input  logic hold_i,   // keep loaded with LEN
    input  logic start_i,  // request a pulse
    output logic busy_o
);
    localparam int unsigned W = hbr_rst_pkg::cnt_width(LEN);
    localparam logic [W-1:0] LEN_V = W'(LEN);

    logic [W-1:0] cnt_q;
    logic         accept;

    if (RETRIG) begin : g_retrig
        assign accept = start_i;
    end else begin : g_once
        assign accept = start_i && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (clr_i)          cnt_q <= '0;
        else if (hold_i)         cnt_q <= LEN_V;
        else if (accept)         cnt_q <= LEN_V;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R3/R6: a running pulse never ends early unless cleared
    a_r3_no_early_end: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > 1 && !clr_i) |=> busy_o);

    // R6: a non-retriggerable pulse ignores starts while running
    a_r6_no_reload: assert property (@(posedge clk) disable iff (rst)
        (!RETRIG && cnt_q > 1 && !clr_i && !hold_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/hbr_rst_ctrl.sv
module hbr_rst_ctrl #(
    parameter int unsigned POR_CYC   = hbr_rst_pkg::POR_HOLD_CYC,
    parameter int unsigned PULSE_LEN = hbr_rst_pkg::PULSE_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good_i,
    input  logic primary_i,
    input  logic hard_wr_i,
    input  logic pci_wr_i,
    input  logic init_wr_i,
    input  logic bist_en_i,
    input  logic host_rst_n_i,
    output logic host_rst_n_o,
    output logic host_rst_oe_o,
    output logic pci_rst_n_o,
    output logic soft_init_n_o,
    output logic pci_clk_o,
    output logic reg_rst_o
);
    import hbr_rst_pkg::*;

    role_e      role;
    logic       is_pri;
    logic [1:0] sync_in, sync_out;
    logic       pg_sync, hin_sync_n;
    logic       por_busy, hard_busy, pci_busy, init_busy;
    rst_cause_t cause;
    logic       host_rst;
    logic       bist_hold;
    logic       pclk_q;

    assign role   = role_e'(primary_i);
    assign is_pri = (role == ROLE_PRIMARY);

    assign sync_in = {host_rst_n_i, pwr_good_i};
    hbr_sync2 #(.W(2)) u_sync (
        .clk (clk), .rst (rst), .d_i (sync_in), .q_o (sync_out)
    );
    assign pg_sync    = sync_out[0];
    assign hin_sync_n = sync_out[1];

    hbr_pulse_cnt #(.LEN(POR_CYC), .RETRIG(1'b1)) u_por (
        .clk (clk), .rst (rst), .clr_i (1'b0),
        .hold_i (is_pri && !pg_sync), .start_i (1'b0), .busy_o (por_busy)
    );

    hbr_pulse_cnt #(.LEN(PULSE_LEN), .RETRIG(1'b1)) u_hard (
        .clk (clk), .rst (rst), .clr_i (!is_pri),
        .hold_i (1'b0), .start_i (hard_wr_i && is_pri), .busy_o (hard_busy)
    );

    hbr_pulse_cnt #(.LEN(PULSE_LEN), .RETRIG(1'b1)) u_pci (
        .clk (clk), .rst (rst), .clr_i (1'b0),
        .hold_i (1'b0), .start_i (pci_wr_i), .busy_o (pci_busy)
    );

    always_comb begin
        cause.por    = is_pri && (!pg_sync || por_busy);
        cause.hard   = is_pri && hard_busy;
        cause.pci    = pci_busy;
        cause.aux_in = !is_pri && !hin_sync_n;
    end

    assign host_rst  = cause.por || cause.hard || cause.aux_in;
    assign bist_hold = is_pri && host_rst && bist_en_i;

    hbr_pulse_cnt #(.LEN(PULSE_LEN), .RETRIG(1'b0)) u_init (
        .clk (clk), .rst (rst),
        .clr_i (!is_pri || (host_rst && !bist_en_i)),
        .hold_i (bist_hold), .start_i (init_wr_i), .busy_o (init_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) pclk_q <= 1'b0;
        else     pclk_q <= !pclk_q;
    end

    assign host_rst_n_o  = !(is_pri && host_rst);
    assign host_rst_oe_o = is_pri;
    assign pci_rst_n_o   = pwr_good_i && !(host_rst || cause.pci);
    assign soft_init_n_o = !(is_pri && (bist_hold || init_busy));
    assign pci_clk_o     = pclk_q;
    assign reg_rst_o     = host_rst;

    a_r1_pg_low_pci: assert property (@(posedge clk) disable iff (rst)
        !pwr_good_i |-> !pci_rst_n_o);

    a_r2_por_hold: assert property (@(posedge clk) disable iff (rst)
        (is_pri && !pg_sync) |=> (!primary_i || !host_rst_n_o));

    a_r3_hard_fires: assert property (@(posedge clk) disable iff (rst)
        (is_pri && hard_wr_i) |=> (!primary_i || (!host_rst_n_o && !pci_rst_n_o)));

    a_r4_pci_fires: assert property (@(posedge clk) disable iff (rst)
        pci_wr_i |=> !pci_rst_n_o);

    a_r5_aux_quiet: assert property (@(posedge clk) disable iff (rst)
        (!primary_i && $past(!primary_i)) |-> (soft_init_n_o && host_rst_n_o && !host_rst_oe_o));

    a_r6_init_fires: assert property (@(posedge clk) disable iff (rst)
        (is_pri && !host_rst && init_wr_i && soft_init_n_o) |=> (!primary_i || !soft_init_n_o));

    a_r8_pclk_toggle: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (pci_clk_o != $past(pci_clk_o)));
endmodule

// File: tb/tb_hbr_rst_ctrl.sv
`timescale 1ns/1ps
module tb_hbr_rst_ctrl;

    logic clk = 1'b0;
    logic rst, pwr_good, primary, hard_wr, pci_wr, init_wr, bist_en, host_rst_n_in;
    logic host_rst_n, host_rst_oe, pci_rst_n, soft_init_n, pci_clk, reg_rst;

    always #2 clk = !clk;

    hbr_rst_ctrl dut (
        .clk (clk), .rst (rst), .pwr_good_i (pwr_good), .primary_i (primary),
        .hard_wr_i (hard_wr), .pci_wr_i (pci_wr), .init_wr_i (init_wr),
        .bist_en_i (bist_en), .host_rst_n_i (host_rst_n_in),
        .host_rst_n_o (host_rst_n), .host_rst_oe_o (host_rst_oe),
        .pci_rst_n_o (pci_rst_n), .soft_init_n_o (soft_init_n),
        .pci_clk_o (pci_clk), .reg_rst_o (reg_rst)
    );

    localparam int S_HOST = 0, S_PCI = 1, S_INIT = 2, S_PCLK = 3, S_REG = 4, S_OE = 5;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic pick(int sig);
        case (sig)
            S_HOST:  return host_rst_n;
            S_PCI:   return pci_rst_n;
            S_INIT:  return soft_init_n;
            S_PCLK:  return pci_clk;
            S_REG:   return reg_rst;
            default: return host_rst_oe;
        endcase
    endfunction

    task automatic check(int sig, logic val, string tag);
        logic act;
        act = pick(sig);
        n_chk++;
        if (act !== val) begin
            n_fail++;
            $display("FAIL %s cyc=%0d sig=%0d actual=%b expected=%b", tag, cyc, sig, act, val);
        end
    endtask

    task automatic expect_at(int at, int sig, logic val, string tag);
        exp_t e;
        e.at = at; e.sig = sig; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare queued expectations at the negedge of their cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                check(q[i].sig, q[i].val, q[i].tag);
                q.delete(i);
            end else if (q[i].at < cyc) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s stale expectation at=%0d actual=x expected=%b", q[i].tag, q[i].at, q[i].val);
                q.delete(i);
            end
        end
    end

    // one-cycle strobe; n = cycle count at the driving negedge, sampled at edge n+1
    task automatic strobe(int which, output int n);
        @(negedge clk);
        n = cyc;
        case (which)
            0: hard_wr = 1'b1;
            1: pci_wr  = 1'b1;
            default: init_wr = 1'b1;
        endcase
        @(negedge clk);
        hard_wr = 1'b0; pci_wr = 1'b0; init_wr = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        int n, n2, e;
        rst = 1'b1; pwr_good = 1'b0; primary = 1'b1; hard_wr = 1'b0; pci_wr = 1'b0;
        init_wr = 1'b0; bist_en = 1'b0; host_rst_n_in = 1'b1;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(S_HOST, 1'b0, "R10 host");
        check(S_INIT, 1'b1, "R10 init");
        check(S_PCLK, 1'b0, "R10 pclk");
        check(S_PCI,  1'b0, "R1 pci while pg low");
        rst = 1'b0;
        n = cyc;
        for (int k = 1; k <= 8; k++) expect_at(n + k, S_PCLK, logic'(k % 2), "R8 pclk");
        repeat (6) @(negedge clk);
        check(S_PCI, 1'b0, "R1 pci low before pg");
        check(S_REG, 1'b1, "R9 reg_rst during por");
        pwr_good = 1'b1;
        e = cyc;
        expect_at(e + 65, S_HOST, 1'b0, "R2 host held");
        expect_at(e + 66, S_HOST, 1'b1, "R2 host released");
        expect_at(e + 65, S_PCI,  1'b0, "R2 pci held");
        expect_at(e + 66, S_PCI,  1'b1, "R2 pci released");
        expect_at(e + 65, S_REG,  1'b1, "R9 reg_rst held");
        expect_at(e + 66, S_REG,  1'b0, "R9 reg_rst released");
        expect_at(e + 66, S_INIT, 1'b1, "R7 no bist init");
        repeat (70) @(negedge clk);

        // R6 soft-init pulse, second request ignored
        strobe(2, n);
        expect_at(n + 1,  S_INIT, 1'b0, "R6 init start");
        expect_at(n + 16, S_INIT, 1'b0, "R6 init last");
        expect_at(n + 17, S_INIT, 1'b1, "R6 init end ignores retrigger");
        repeat (4) @(negedge clk);
        strobe(2, n2);
        repeat (20) @(negedge clk);

        // R3 hard reset, R6 init ignored during host reset
        strobe(0, n);
        expect_at(n + 1,  S_HOST, 1'b0, "R3 host start");
        expect_at(n + 16, S_HOST, 1'b0, "R3 host last");
        expect_at(n + 17, S_HOST, 1'b1, "R3 host end");
        expect_at(n + 1,  S_PCI,  1'b0, "R3 pci start");
        expect_at(n + 17, S_PCI,  1'b1, "R3 pci end");
        expect_at(n + 1,  S_REG,  1'b1, "R9 reg_rst hard");
        expect_at(n + 17, S_REG,  1'b0, "R9 reg_rst hard end");
        expect_at(n + 1,  S_INIT, 1'b1, "R7 no bist init high");
        expect_at(n + 5,  S_INIT, 1'b1, "R6 init ignored in reset");
        expect_at(n + 18, S_INIT, 1'b1, "R6 init stays idle");
        @(negedge clk);
        strobe(2, n2);
        repeat (25) @(negedge clk);

        // R4 PCI-only reset
        strobe(1, n);
        expect_at(n + 1,  S_PCI,  1'b0, "R4 pci start");
        expect_at(n + 16, S_PCI,  1'b0, "R4 pci last");
        expect_at(n + 17, S_PCI,  1'b1, "R4 pci end");
        expect_at(n + 1,  S_HOST, 1'b1, "R4 host untouched");
        expect_at(n + 8,  S_HOST, 1'b1, "R4 host untouched mid");
        repeat (20) @(negedge clk);

        // R3 retrigger extends
        strobe(0, n);
        repeat (4) @(negedge clk);
        strobe(0, n2);
        expect_at(n + 17,  S_HOST, 1'b0, "R3 retrigger extends");
        expect_at(n2 + 16, S_HOST, 1'b0, "R3 retrigger last");
        expect_at(n2 + 17, S_HOST, 1'b1, "R3 retrigger end");
        repeat (25) @(negedge clk);

        // R7 BIST request across release
        bist_en = 1'b1;
        strobe(0, n);
        expect_at(n + 1,  S_INIT, 1'b0, "R7 init during reset");
        expect_at(n + 17, S_HOST, 1'b1, "R7 host released");
        expect_at(n + 17, S_INIT, 1'b0, "R7 init across release");
        expect_at(n + 32, S_INIT, 1'b0, "R7 init last");
        expect_at(n + 33, S_INIT, 1'b1, "R7 init end");
        repeat (40) @(negedge clk);
        bist_en = 1'b0;

        // R5 auxiliary role
        primary = 1'b0;
        repeat (2) @(negedge clk);
        check(S_OE,   1'b0, "R5 oe off");
        check(S_HOST, 1'b1, "R5 host drive idle");
        check(S_INIT, 1'b1, "R5 init idle");
        host_rst_n_in = 1'b0;
        n = cyc;
        expect_at(n + 1, S_REG, 1'b0, "R5 sync stage one");
        expect_at(n + 2, S_REG, 1'b1, "R5 sampled reset");
        expect_at(n + 2, S_PCI, 1'b0, "R5 pci follows input");
        repeat (5) @(negedge clk);
        host_rst_n_in = 1'b1;
        n = cyc;
        expect_at(n + 1, S_REG, 1'b1, "R5 release stage one");
        expect_at(n + 2, S_REG, 1'b0, "R5 released");
        expect_at(n + 2, S_PCI, 1'b1, "R5 pci released");
        repeat (5) @(negedge clk);
        strobe(0, n);
        expect_at(n + 1, S_PCI,  1'b1, "R5 hard ignored pci");
        expect_at(n + 1, S_REG,  1'b0, "R5 hard ignored reg");
        expect_at(n + 1, S_HOST, 1'b1, "R5 hard ignored host");
        strobe(2, n);
        expect_at(n + 1, S_INIT, 1'b1, "R5 init ignored");
        expect_at(n + 3, S_INIT, 1'b1, "R5 init stays");
        repeat (5) @(negedge clk);
        strobe(1, n);
        expect_at(n + 1, S_PCI, 1'b0, "R4 pci in aux");
        expect_at(n + 17, S_PCI, 1'b1, "R4 pci in aux end");
        repeat (20) @(negedge clk);
        pwr_good = 1'b0;
        #1;
        check(S_PCI, 1'b0, "R1 pci immediate in aux");
        repeat (3) @(negedge clk);
        check(S_REG, 1'b0, "R5 no por in aux");
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
        check(S_PCI, 1'b1, "R1 pci back in aux");

        wait (q.size() == 0);
        @(negedge clk);
        summary();
        $finish;
    end
endmodule